// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous request port and a 64K x 8 asynchronous static RAM. It accepts one read or one write at a time through a valid/ready handshake and produces the device strobes: two chip selects of opposite polarity (`sram_cs1_n` active low, `sram_cs2` active high), an active-low output enable and an active-low write enable. Each phase length is a whole number of clock cycles, computed at elaboration from a clock-period parameter and a speed-grade parameter (55 ns or 70 ns).

The data bus is split into an output byte, an input byte and a driver enable, so the surrounding chip can build the bidirectional pad. The device output enable stays high for the whole of a write. The controller drives the bus only while the write enable is low, and only once the device has had time to release the bus after its last read. A read returns its byte on `rd_data` with a one-cycle `rd_valid` pulse.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs are: both chip selects inactive (`sram_cs1_n`=1, `sram_cs2`=0), `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R2: Every timing minimum becomes ceil(ns / CLK_PERIOD_NS) cycles, with a floor of one cycle. With a 4 ns clock and the 55 ns grade this gives: read wait 14 cycles (max of 55 ns access and 25 ns output-enable access), write pulse 12 cycles (max of 40 ns pulse, 25 ns data setup and 45 ns select/address to end of write), cycle time 14 cycles and bus turnaround 5 cycles (20 ns).
- R3: A read selects the device (`sram_cs1_n`=0, `sram_cs2`=1), drives `sram_oe_n`=0 with `sram_we_n`=1 and presents the registered request address. The byte returned on `rd_data` is the one the device holds at that address.
- R4: For a read, `rd_valid` is high for exactly one cycle. It rises at the rising edge that comes the read-wait count (14 by default) after the accepting edge, and `rd_data` is sampled at that same edge. A write produces no `rd_valid`.
- R5: During a write, `sram_oe_n` stays high throughout. `sram_we_n` is low for exactly the write-pulse count (12 by default).
- R6: `sram_dq_oe` is high only while `sram_we_n` is low and `sram_oe_n` is high. It is first raised only after `sram_oe_n` has been high for at least the turnaround count (5 cycles by default).
- R7: While the write data is driven it holds one value. The write ends at a single edge where `sram_we_n` rises, both chip selects go inactive and `sram_dq_oe` falls. By then the data has been driven for at least the data-setup minimum.
- R8: `req_ready` drops at the accepting edge and stays low at least the cycle-time count (exactly 14 cycles for a read by default). Requests presented while it is low are ignored: they cause no strobe and change no stored byte.
- R9: `sram_addr` and the driven write byte do not change while `req_ready` is low, even if the request inputs change.
- R10: Whenever no operation is in progress, the device is deselected (`sram_cs1_n`=1, `sram_cs2`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| sram_addr | output | 16 | Device address |
| sram_cs1_n | output | 1 | Device select, active low |
| sram_cs2 | output | 1 | Device select, active high |
| sram_oe_n | output | 1 | Device output enable, active low |
| sram_we_n | output | 1 | Device write enable, active low |
| sram_dq_out | output | 8 | Byte driven towards the device |
| sram_dq_oe | output | 1 | Enable for the controller's bus driver |
| sram_dq_in | input | 8 | Byte read from the device bus |

## Verification
A read is accepted on one rising edge, and `rd_valid` is due 14 edges later. The bench counts edges from the accepting edge and samples every output at the falling edge that follows, so the cycle each result appears in is unambiguous. The bench's device model presents valid data only 55 ns after the last strobe or address change, so a sample taken even one edge early returns a marker byte. A monitor reads the strobes as they stood before each rising edge. It measures the write-enable low time (12 cycles), the output-enable high time before the driver turns on (at least 5 cycles) and the alignment at the end of a write, and it commits written bytes to the model only at the end-of-write edge.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD       = 3'd1,
    ST_WR_SETUP = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_HOLD     = 3'd4
  } ctrl_state_t;

  // round a nanosecond minimum up to whole clock cycles, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned q;
    q = (ns + period - 1) / period;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last,
  output logic             idle
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // last: the coming edge completes the loaded number of cycles
  assign last = (cnt_q == CNT_W'(1));
  assign idle = (cnt_q == '0);

  // R2: the counter only ever steps down by one between loads
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/sram_bus_turnaround.sv
`timescale 1ns/1ps
module sram_bus_turnaround #(
  parameter int unsigned TURN_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic safe
);

  localparam int unsigned W = $clog2(TURN_CYC + 1);

  logic [W-1:0] hi_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q <= W'(TURN_CYC);
    end else if (!oe_n) begin
      hi_cnt_q <= '0;
    end else if (hi_cnt_q < W'(TURN_CYC)) begin
      hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign safe = (hi_cnt_q >= W'(TURN_CYC));

  // R6: output enable seen low on one edge means the bus is not yet safe on the next
  AST_TURN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> !safe); // R6

endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
module sram_read_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) begin
        dout <= din;
      end
    end
  end

  // R4: returned byte holds between captures
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(capture) |-> $stable(dout)); // R4

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned SPEED_GRADE   = 55,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs1_n,
  output logic              sram_cs2,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  // nanosecond minimums per speed grade
  localparam bit          SLOW     = (SPEED_GRADE >= 70);
  localparam int unsigned CYC_NS   = SLOW ? 70 : 55;
  localparam int unsigned ACC_NS   = SLOW ? 70 : 55;
  localparam int unsigned OEA_NS   = SLOW ? 35 : 25;
  localparam int unsigned SEL_NS   = SLOW ? 60 : 45;
  localparam int unsigned PULSE_NS = SLOW ? 50 : 40;
  localparam int unsigned SETUP_NS = SLOW ? 30 : 25;
  localparam int unsigned RELEASE_NS = SLOW ? 25 : 20;

  // cycle counts
  localparam int unsigned CYC_C     = ns_to_cyc(CYC_NS, CLK_PERIOD_NS);
  localparam int unsigned ACC_C     = ns_to_cyc(ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned OEA_C     = ns_to_cyc(OEA_NS, CLK_PERIOD_NS);
  localparam int unsigned SEL_C     = ns_to_cyc(SEL_NS, CLK_PERIOD_NS);
  localparam int unsigned PULSE_C   = ns_to_cyc(PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned SETUP_C   = ns_to_cyc(SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned TURN_C    = ns_to_cyc(RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned RD_WAIT_C = max2(ACC_C, OEA_C);
  localparam int unsigned RD_CYC_C  = max2(CYC_C, RD_WAIT_C);
  localparam int unsigned WR_PULSE_C = max2(max2(PULSE_C, SETUP_C), SEL_C);
  localparam int unsigned WR_CYC_C  = CYC_C;
  localparam int unsigned CNT_W     = $clog2(max2(RD_CYC_C, max2(WR_CYC_C, WR_PULSE_C)) + 1);

  ctrl_state_t state_q;

  logic             accept;
  logic             cyc_load, ph_load;
  logic [CNT_W-1:0] cyc_val, ph_val;
  logic             cyc_last, cyc_idle, cyc_done;
  logic             ph_last, ph_idle;
  logic             turn_safe;
  logic             capture;

  assign accept   = req_valid && req_ready;
  assign cyc_done = cyc_last || cyc_idle;
  assign capture  = (state_q == ST_RD) && ph_last;

  always_comb begin
    cyc_load = accept;
    cyc_val  = req_write ? CNT_W'(WR_CYC_C) : CNT_W'(RD_CYC_C);
    ph_load  = 1'b0;
    ph_val   = CNT_W'(RD_WAIT_C);
    if (accept && !req_write) begin
      ph_load = 1'b1;
    end else if (state_q == ST_WR_SETUP && turn_safe) begin
      ph_load = 1'b1;
      ph_val  = CNT_W'(WR_PULSE_C);
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_cycle_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (cyc_load),
    .load_val (cyc_val),
    .last     (cyc_last),
    .idle     (cyc_idle)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_phase_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .last     (ph_last),
    .idle     (ph_idle)
  );

  sram_bus_turnaround #(.TURN_CYC(TURN_C)) u_turnaround (
    .clk  (clk),
    .rst  (rst),
    .oe_n (sram_oe_n),
    .safe (turn_safe)
  );

  sram_read_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .din     (sram_dq_in),
    .dout    (rd_data),
    .valid   (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_ready   <= 1'b1;
      sram_addr   <= '0;
      sram_cs1_n  <= 1'b1;
      sram_cs2    <= 1'b0;
      sram_oe_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_wdata;
            sram_cs1_n  <= 1'b0;
            sram_cs2    <= 1'b1;
            req_ready   <= 1'b0;
            if (req_write) begin
              state_q <= ST_WR_SETUP;
            end else begin
              sram_oe_n <= 1'b0;
              state_q   <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (ph_last) begin
            sram_oe_n  <= 1'b1;
            sram_cs1_n <= 1'b1;
            sram_cs2   <= 1'b0;
            if (cyc_done) begin
              req_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        ST_WR_SETUP: begin
          if (turn_safe) begin
            sram_we_n  <= 1'b0;
            sram_dq_oe <= 1'b1;
            state_q    <= ST_WR_PULSE;
          end
        end
        ST_WR_PULSE: begin
          if (ph_last) begin
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            sram_cs1_n <= 1'b1;
            sram_cs2   <= 1'b0;
            if (cyc_done) begin
              req_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (cyc_done) begin
            req_ready <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------------------------------------------------------
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!sram_oe_n && !sram_we_n)); // R5

  AST_DRIVE_WITH_WE: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_we_n && sram_oe_n)); // R6

  AST_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> $past(sram_oe_n)); // R6

  AST_WRITE_END: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (sram_cs1_n && !sram_cs2 && !sram_dq_oe)); // R7

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R9

  AST_IDLE_DESEL: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (sram_cs1_n && !sram_cs2 && sram_we_n && sram_oe_n)); // R10

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

  localparam int PER     = 4;
  localparam int RD_LAT  = 14;
  localparam int WE_LEN  = 12;
  localparam int CYC     = 14;
  localparam int TURN    = 5;
  localparam int ACC_NS  = 55;
  localparam int SETUP_NS = 25;
  localparam int NVEC    = 9;

  // {write, address, data}
  localparam logic [24:0] VEC [0:NVEC-1] = '{
    {1'b1, 16'h0012, 8'hA5},
    {1'b1, 16'hFF34, 8'h3C},
    {1'b0, 16'h0012, 8'hA5},
    {1'b1, 16'h1256, 8'h00},
    {1'b0, 16'hFF34, 8'h3C},
    {1'b1, 16'h0078, 8'hFF},
    {1'b0, 16'h1256, 8'h00},
    {1'b0, 16'h0078, 8'hFF},
    {1'b0, 16'h0012, 8'hA5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [15:0] sram_addr;
  logic        sram_cs1_n, sram_cs2, sram_oe_n, sram_we_n;
  logic [7:0]  sram_dq_out;
  logic        sram_dq_oe;
  logic [7:0]  sram_dq_in = 8'hEE;

  int total = 0;
  int bad   = 0;
  bit done_flag = 1'b0;

  sram_async_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(55)) u_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .sram_addr(sram_addr),
    .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] mem_q [256] = '{default: 8'h00};
  longint     t_chg = 0;

  always @(sram_addr or sram_oe_n or sram_cs1_n or sram_cs2 or sram_we_n)
    t_chg = longint'($time);

  always begin
    #1;
    if (!sram_cs1_n && sram_cs2 && !sram_oe_n && sram_we_n &&
        (longint'($time) - t_chg >= ACC_NS))
      sram_dq_in = mem_q[sram_addr[7:0]];
    else
      sram_dq_in = 8'hEE;
  end

  // ---------------- strobe monitor (pre-edge values) ----------------
  int          we_lo = 0;
  int          dq_hits = 0;
  int          oe_hi = 100;
  int          we_falls = 0;
  logic [7:0]  dq_last = '0;
  bit          we_prev = 1'b1;
  bit          dq_prev = 1'b0;
  bit          rdy_prev = 1'b1;
  logic [15:0] addr_prev = '0;

  always @(posedge clk) begin
    if (!rst) begin
      if (sram_dq_oe)
        check(!sram_we_n && sram_oe_n, "R6 driver on only with WE low, OE high",
              int'({sram_we_n, sram_oe_n}), 1);
      if (sram_dq_oe && !dq_prev)
        check(oe_hi >= TURN, "R6 turnaround before driving", oe_hi, TURN);
      if (!sram_we_n) begin
        if (we_prev) we_falls++;
        if (we_lo > 0 && sram_dq_oe && sram_dq_out != dq_last)
          check(1'b0, "R7 write data stable", int'(sram_dq_out), int'(dq_last));
        we_lo++;
        if (sram_dq_oe) dq_hits++;
        dq_last = sram_dq_out;
      end else if (we_lo > 0) begin
        check(we_lo == WE_LEN, "R2 R5 write pulse length", we_lo, WE_LEN);
        check(dq_hits * PER >= SETUP_NS, "R7 data setup", dq_hits * PER, SETUP_NS);
        check(sram_cs1_n && !sram_cs2 && !sram_dq_oe, "R7 aligned end of write",
              int'({sram_cs1_n, sram_cs2, sram_dq_oe}), 4);
        mem_q[sram_addr[7:0]] = dq_last;
        we_lo = 0;
        dq_hits = 0;
      end
      if (!req_ready && !rdy_prev)
        check(sram_addr == addr_prev, "R9 address held", int'(sram_addr), int'(addr_prev));
      oe_hi = sram_oe_n ? ((oe_hi < 1000) ? oe_hi + 1 : oe_hi) : 0;
      we_prev   = sram_we_n;
      dq_prev   = sram_dq_oe;
      rdy_prev  = req_ready;
      addr_prev = sram_addr;
    end
  end

  // ---------------- one request ----------------
  task automatic do_op(input bit wr, input logic [15:0] a, input logic [7:0] d,
                       output int lat, output logic [7:0] rdat,
                       output int busy, output int pulses);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_addr = ~a; req_wdata = ~d;
    if (wr)
      check(!sram_cs1_n && sram_cs2 && sram_oe_n && sram_addr == a,
            "R5 write selects with OE high", int'({sram_cs1_n, sram_cs2, sram_oe_n}), 3);
    else
      check(!sram_cs1_n && sram_cs2 && !sram_oe_n && sram_we_n && sram_addr == a,
            "R3 read strobes", int'({sram_cs1_n, sram_cs2, sram_oe_n, sram_we_n}), 5);
    n = 0; lat = 0; pulses = 0; rdat = 8'h00;
    while (!req_ready) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rd_valid) begin pulses++; lat = n; rdat = rd_data; end
    end
    busy = n;
    check(sram_cs1_n && !sram_cs2, "R10 deselected after op",
          int'({sram_cs1_n, sram_cs2}), 2);
    @(posedge clk);
    @(negedge clk);
    check(!rd_valid, "R4 valid lasts one cycle", int'(rd_valid), 0);
  endtask

  initial begin
    int lat, busy, pulses, falls0;
    logic [7:0] rdat;
    logic [24:0] v;

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sram_cs1_n && !sram_cs2 && sram_oe_n && sram_we_n && !sram_dq_oe &&
          !rd_valid && req_ready, "R1 reset outputs",
          int'({sram_cs1_n, sram_cs2, sram_oe_n, sram_we_n, sram_dq_oe, rd_valid, req_ready}),
          7'b1011001);
    rst = 1'b0;
    @(negedge clk);
    check(sram_cs1_n && !sram_cs2 && req_ready && !sram_dq_oe, "R1 first cycle after reset",
          int'({sram_cs1_n, sram_cs2, req_ready, sram_dq_oe}), 4'b1010);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      do_op(v[24], v[23:8], v[7:0], lat, rdat, busy, pulses);
      if (v[24]) begin
        check(pulses == 0, "R4 no valid on write", pulses, 0);
        check(busy >= CYC, "R8 write busy length", busy, CYC);
      end else begin
        check(lat == RD_LAT, "R2 R4 read latency", lat, RD_LAT);
        check(pulses == 1, "R4 one valid pulse", pulses, 1);
        check(rdat == v[7:0], "R3 read data", int'(rdat), int'(v[7:0]));
        check(busy == CYC, "R8 read busy length", busy, CYC);
      end
    end

    // address corners
    do_op(1'b1, 16'hFFFF, 8'h81, lat, rdat, busy, pulses);
    do_op(1'b1, 16'h0000, 8'h7E, lat, rdat, busy, pulses);
    do_op(1'b0, 16'hFFFF, 8'h00, lat, rdat, busy, pulses);
    check(rdat == 8'h81, "R3 read top address", int'(rdat), 8'h81);
    do_op(1'b0, 16'h0000, 8'h00, lat, rdat, busy, pulses);
    check(rdat == 8'h7E, "R3 read address zero", int'(rdat), 8'h7E);
    check(lat == RD_LAT, "R4 latency after write", lat, RD_LAT);

    // R8: request held while busy is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    falls0 = we_falls;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0012; req_wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_wdata = 8'h11; req_addr = 16'h0034;
    pulses = 0; rdat = 8'h00;
    while (!req_ready) begin
      @(negedge clk);
      if (rd_valid) begin pulses++; rdat = rd_data; end
    end
    req_valid = 1'b0; req_write = 1'b0;
    check(rdat == 8'hA5, "R8 read during ignored request", int'(rdat), 8'hA5);
    repeat (4) @(negedge clk);
    check(we_falls == falls0, "R8 no write strobe while busy", we_falls, falls0);
    check(req_ready && sram_cs1_n, "R8 ignored request not accepted",
          int'({req_ready, sram_cs1_n}), 3);
    do_op(1'b0, 16'h0012, 8'h00, lat, rdat, busy, pulses);
    check(rdat == 8'hA5, "R8 stored byte unchanged", int'(rdat), 8'hA5);
    do_op(1'b0, 16'hFF34, 8'h00, lat, rdat, busy, pulses);
    check(rdat == 8'h3C, "R8 other byte unchanged", int'(rdat), 8'h3C);

    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule